// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-rank SDR SDRAM from power-on to normal operation, then keeps it refreshed. After reset it holds clock-enable high and drives the idle command on the command pins. It waits for a start pulse. It then counts a power-up pause of 200 µs, derived from the clock frequency parameter. Next it issues one precharge-all, exactly eight auto-refresh commands and one mode-register load. After the mode-register recovery time of three cycles it raises `init_done`.

Command spacing after the precharge and after each refresh comes from configuration inputs. The mode word carries the configured CAS latency. It always selects burst length 1 and sequential bursts.

Once initialization is complete, a refresh timer reloads from the programmed interval. Each time the timer expires it raises `refresh_req`. The request stays asserted until the rest of the controller acknowledges it. The expected interval is the floor of 15.6 µs times the clock frequency, which is 1560 cycles at 100 MHz. It is computed outside the block and applied to `refi`.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and from reset release until a start pulse is sampled, the command pins carry NOP: `cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1. During the same time `addr`=0, `ba`=0, `init_done`=0 and `refresh_req`=0. `cke` is 0 while reset is asserted and 1 from the first cycle after reset release.
- R2: Call the rising edge that samples `start`=1 in the idle state edge 0, and the cycle that follows edge n cycle n. Cycles 1 to PAUSE_CYC carry NOP, where PAUSE_CYC = CLK_MHZ*PAUSE_US.
- R3: Cycle PAUSE_CYC+1 carries PRECHARGE ALL. The pins are `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0. `addr` has only bit 10 set, and `ba`=0.
- R4: Exactly eight AUTO REFRESH commands follow. The pins are `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1, with `addr`=0 and `ba`=0. The first comes `t_rp` cycles after the precharge, and each later one comes `t_rc` cycles after the previous one. A spacing input of 0 acts as 1. All cycles in between carry NOP.
- R5: LOAD MODE REGISTER comes `t_rc` cycles after the eighth refresh. All four command pins are 0 and `ba`=0. `addr[6:4]` equals `cas_lat`, `addr[3]`=0 (sequential), `addr[2:0]`=000 (burst length 1), and all other address bits are 0.
- R6: The three cycles after the mode load carry NOP. `init_done` rises in the fourth cycle after the mode load and stays high until reset. NOP is driven on every later cycle.
- R7: `refresh_req` first rises `refi` cycles after `init_done` rises, then every `refi` cycles. With CLK_MHZ=1 the bench programs `refi` = floor(15.6*CLK_MHZ) = 15.
- R8: Once raised, `refresh_req` stays high until `refresh_ack` is sampled high. It is low in the following cycle, unless the timer expires in that same cycle. An expiry takes priority over an acknowledge.
- R9: A `start` pulse sampled while the sequence is running or finished has no effect on the command stream or on `init_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts the power-up sequence (sampled in idle only) |
| cas_lat | input | 3 | CAS latency placed in the mode word |
| t_rp | input | TW | Cycles from precharge to the first refresh |
| t_rc | input | TW | Cycles from a refresh to the next command |
| refi | input | RW | Refresh interval in cycles (at least 1) |
| refresh_ack | input | 1 | Acknowledge for the pending refresh request |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address |
| init_done | output | 1 | Memory ready for normal traffic |
| refresh_req | output | 1 | Periodic refresh request |

## Verification
Every command appears in a cycle fixed by arithmetic from the start edge:

| Result | Cycle after the start edge |
|--------|----------------------------|
| Precharge | PAUSE_CYC+1 |
| Refresh i (i = 0 to 7) | PAUSE_CYC+1+t_rp+i*t_rc |
| Mode load, cycle M | PAUSE_CYC+1+t_rp+8*t_rc |
| `init_done` rising | M+4 |
| Refresh request k | M+4+k*refi |

A request clears one cycle after the cycle in which the acknowledge is driven. The bench counts the cycle index itself and compares every output pin once per cycle against these formulas, sampling on the falling edge so that each comparison sees the values registered at the preceding rising edge. Acknowledges arrive 0, 1 or 2 cycles after each request. Some runs never acknowledge at all, and some runs pulse `start` again in the middle of the sequence.

// File: rtl/sdram_init_pkg.sv
// Package: shared command and state types for the SDRAM init sequencer.
// Assumes a single-rank SDR device and a fixed eight-refresh power-up burst.
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PAUSE,
        ST_PRE,
        ST_WRP,
        ST_REF,
        ST_WRC,
        ST_MRS,
        ST_WMRD,
        ST_DONE
    } seq_state_e;

    localparam int REF_BURST = 8;
    localparam int MRD_CYC   = 3;

endpackage

// File: rtl/sdram_init_fsm.sv
// Module: sdram_init_fsm
// Walks the power-up order: pause, precharge, eight refreshes, mode load and
// mode recovery, then done. A single down-counter times every wait.
// Assumes t_rp and t_rc stay stable while the sequence runs. A value of 0 is
// treated as 1.
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int PAUSE_CYC = 20000,
    parameter int TW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] t_rp,
    input  logic [TW-1:0] t_rc,
    output cmd_e          cmd,
    output logic          done
);

    localparam int PW    = $clog2(PAUSE_CYC + 1);
    localparam int CNT_W = (PW > TW) ? PW : TW;
    localparam int RC_W  = $clog2(REF_BURST + 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [RC_W-1:0]  nref;

    // Sequence state, wait counter and refresh tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            nref  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cnt   <= CNT_W'(PAUSE_CYC - 1);
                        state <= ST_PAUSE;
                    end
                end
                ST_PAUSE: begin
                    if (cnt == '0) state <= ST_PRE;
                    else           cnt   <= cnt - CNT_W'(1);
                end
                ST_PRE: begin
                    if (t_rp <= TW'(1)) begin
                        state <= ST_REF;
                    end else begin
                        cnt   <= CNT_W'(t_rp) - CNT_W'(2);
                        state <= ST_WRP;
                    end
                end
                ST_WRP: begin
                    if (cnt == '0) state <= ST_REF;
                    else           cnt   <= cnt - CNT_W'(1);
                end
                ST_REF: begin
                    nref <= nref + RC_W'(1);
                    if (t_rc <= TW'(1)) begin
                        state <= (nref == RC_W'(REF_BURST - 1)) ? ST_MRS : ST_REF;
                    end else begin
                        cnt   <= CNT_W'(t_rc) - CNT_W'(2);
                        state <= ST_WRC;
                    end
                end
                ST_WRC: begin
                    if (cnt == '0)
                        state <= (nref == RC_W'(REF_BURST)) ? ST_MRS : ST_REF;
                    else
                        cnt <= cnt - CNT_W'(1);
                end
                ST_MRS: begin
                    cnt   <= CNT_W'(MRD_CYC - 1);
                    state <= ST_WMRD;
                end
                ST_WMRD: begin
                    if (cnt == '0) state <= ST_DONE;
                    else           cnt   <= cnt - CNT_W'(1);
                end
                ST_DONE: state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Command to issue in the current cycle, decoded from the state.
    always_comb begin
        case (state)
            ST_PRE:  cmd = CMD_PRE;
            ST_REF:  cmd = CMD_REF;
            ST_MRS:  cmd = CMD_MRS;
            default: cmd = CMD_NOP;
        endcase
    end

    assign done = (state == ST_DONE);

    assert_burst_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MRS) |-> (nref == RC_W'(REF_BURST)));

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_IDLE));

endmodule

// File: rtl/sdram_cmd_enc.sv
// Module: sdram_cmd_enc
// Maps an abstract command onto the active-low command pins and the address.
// Assumes ADDR_W >= 11, so that bit 10 exists for precharge-all.
module sdram_cmd_enc
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  cmd_e              cmd,
    input  logic [2:0]        cas_lat,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);

    // Pin levels and address word for each command.
    always_comb begin
        addr = '0;
        ba   = '0;
        cs_n = 1'b0;
        case (cmd)
            CMD_PRE: begin
                {ras_n, cas_n, we_n} = 3'b010;
                addr[10] = 1'b1;
            end
            CMD_REF: {ras_n, cas_n, we_n} = 3'b001;
            CMD_MRS: begin
                {ras_n, cas_n, we_n} = 3'b000;
                addr[6:4] = cas_lat;
            end
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
    end

endmodule

// File: rtl/sdram_refresh_timer.sv
// Module: sdram_refresh_timer
// Down-counter that, while enabled, raises a refresh request every refi
// cycles. The request is held until it is acknowledged, and an expiry in the
// same cycle as an acknowledge wins. Assumes refi >= 1.
module sdram_refresh_timer #(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [RW-1:0] refi,
    input  logic          ack,
    output logic          req
);

    logic [RW-1:0] tmr;

    // Interval countdown and request latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr <= '0;
            req <= 1'b0;
        end else if (!en) begin
            tmr <= refi - RW'(1);
            req <= 1'b0;
        end else if (tmr == '0) begin
            tmr <= refi - RW'(1);
            req <= 1'b1;
        end else begin
            tmr <= tmr - RW'(1);
            if (ack) req <= 1'b0;
        end
    end

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);

    assert_req_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(en));

endmodule

// File: rtl/sdram_init_seq.sv
// Module: sdram_init_seq (top)
// SDRAM power-up sequencer followed by a periodic refresh requester.
// Assumes the configuration inputs are stable from start until init_done.
// The pause length is CLK_MHZ*PAUSE_US cycles.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ  = 100,
    parameter int PAUSE_US = 200,
    parameter int ADDR_W   = 13,
    parameter int BA_W     = 2,
    parameter int TW       = 4,
    parameter int RW       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cas_lat,
    input  logic [TW-1:0]     t_rp,
    input  logic [TW-1:0]     t_rc,
    input  logic [RW-1:0]     refi,
    input  logic              refresh_ack,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done,
    output logic              refresh_req
);

    localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;

    cmd_e cmd;

    // Clock enable: low in reset, high from the first cycle after it.
    always_ff @(posedge clk) begin
        if (!rst_n) cke <= 1'b0;
        else        cke <= 1'b1;
    end

    sdram_init_fsm #(
        .PAUSE_CYC (PAUSE_CYC),
        .TW        (TW)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .t_rp  (t_rp),
        .t_rc  (t_rc),
        .cmd   (cmd),
        .done  (init_done)
    );

    sdram_cmd_enc #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_enc (
        .cmd     (cmd),
        .cas_lat (cas_lat),
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .addr    (addr),
        .ba      (ba)
    );

    sdram_refresh_timer #(
        .RW (RW)
    ) u_refresh (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .refi  (refi),
        .ack   (refresh_ack),
        .req   (refresh_req)
    );

    logic pin_pre, pin_mrs;
    assign pin_pre = !cs_n && !ras_n && cas_n && !we_n;
    assign pin_mrs = !cs_n && !ras_n && !cas_n && !we_n;

    assert_pre_a10_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_pre |-> addr[10]);

    assert_mrd_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(pin_mrs, 4));

    assert_no_req_before_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !refresh_req);

endmodule

// File: tb/sdram_init_seq_bench.sv
// Bench: sweeps spacing and CAS settings on a 1 MHz-parameterized instance
// and checks every pin in every cycle against arithmetic expectations.
module sdram_init_seq_bench;

    localparam int MHZ    = 1;
    localparam int PUS    = 200;
    localparam int P      = MHZ * PUS;
    localparam int REFI   = (156 * MHZ) / 10;
    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;
    localparam int TW     = 4;
    localparam int RW     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [2:0]        cas_lat = 3'd2;
    logic [TW-1:0]     t_rp = '0;
    logic [TW-1:0]     t_rc = '0;
    logic [RW-1:0]     refi = RW'(REFI);
    logic              refresh_ack = 1'b0;
    logic              cke, cs_n, ras_n, cas_n, we_n, init_done, refresh_req;
    logic [ADDR_W-1:0] addr;
    logic [BA_W-1:0]   ba;

    int tests = 0;
    int fails = 0;

    sdram_init_seq #(
        .CLK_MHZ (MHZ), .PAUSE_US (PUS), .ADDR_W (ADDR_W),
        .BA_W (BA_W), .TW (TW), .RW (RW)
    ) u_sdram_init_seq (
        .clk (clk), .rst_n (rst_n), .start (start), .cas_lat (cas_lat),
        .t_rp (t_rp), .t_rc (t_rc), .refi (refi), .refresh_ack (refresh_ack),
        .cke (cke), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .addr (addr), .ba (ba), .init_done (init_done), .refresh_req (refresh_req)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int pins();
        return {28'd0, cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic run(input int trp, input int trc, input int cas,
                       input bit noack, input bit poke);
        int erp, erc, r0, m, d, n, k, ack_at;
        bit exp_req, ack_last, set;
        int exp_pins, exp_addr;
        string tag;
        erp = (trp < 1) ? 1 : trp;
        erc = (trc < 1) ? 1 : trc;
        r0  = P + 1 + erp;
        m   = r0 + 8 * erc;
        d   = m + 4;
        n   = d + 3 * REFI + 2;
        rst_n = 1'b0; start = 1'b0; refresh_ack = 1'b0;
        t_rp = TW'(trp); t_rc = TW'(trc); cas_lat = 3'(cas);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state during reset
        chk(pins() == 7 && cke == 0 && init_done == 0 && refresh_req == 0 && addr == 0,
            "R1", "reset pins/cke/done/req", {pins(), 3'(cke), 1'(init_done)}, 7 << 4);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            // R1: idle before start
            chk(pins() == 7 && cke == 1 && init_done == 0 && addr == 0 && ba == 0,
                "R1", "idle pins/cke", {pins(), 1'(cke)}, (7 << 1) | 1);
        end
        start = 1'b1;
        exp_req = 0; ack_last = 0; k = 0; ack_at = -1;
        for (int s = 1; s <= n; s++) begin
            @(negedge clk);
            start = poke && (s == 50 || s == m + 2);
            exp_addr = 0;
            if (s <= P) begin
                exp_pins = 7; tag = "R2";
            end else if (s == P + 1) begin
                exp_pins = 2; exp_addr = 1 << 10; tag = "R3";
            end else if (s >= r0 && s < m && ((s - r0) % erc) == 0) begin
                exp_pins = 1; tag = "R4";
            end else if (s == m) begin
                exp_pins = 0; exp_addr = cas << 4; tag = "R5";
            end else if (s < m) begin
                exp_pins = 7; tag = "R4";
            end else begin
                exp_pins = 7; tag = "R6";
            end
            if (poke) tag = {tag, " R9"};
            chk(pins() == exp_pins, tag, "command pins", pins(), exp_pins);
            chk(int'(addr) == exp_addr && ba == 0, tag, "address", int'(addr), exp_addr);
            chk(init_done == (s >= d), poke ? "R6 R9" : "R6", "init_done",
                int'(init_done), int'(s >= d));
            set = (s > d) && (((s - d) % REFI) == 0);
            exp_req = set ? 1'b1 : (ack_last ? 1'b0 : exp_req);
            chk(refresh_req == exp_req, set ? "R7" : "R8", "refresh_req",
                int'(refresh_req), int'(exp_req));
            if (set) begin
                ack_at = s + (k % 3);
                k++;
            end
            refresh_ack = !noack && (s == ack_at);
            ack_last = refresh_ack;
        end
        refresh_ack = 1'b0;
        start = 1'b0;
    endtask

    initial begin
        int trps[5] = '{0, 1, 2, 3, 5};
        int trcs[4] = '{1, 2, 4, 7};
        int idx = 0;
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 4; b++) begin
                for (int c = 2; c <= 3; c++) begin
                    run(trps[a], trcs[b], c, (idx % 5) == 3, (idx % 2) == 1);
                    idx++;
                end
            end
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule